// File: doc/BRIEF.md
# Software Window onto Translation Buffer Storage

This block holds the storage of a 4-way, 32-set address translation buffer and gives software direct read and write reach into it through two fixed address windows on a simple register bus. One window covers the tag side (page number, valid flag, address-space ID) and the other covers the data side (one 32-bit page attribute word per entry). Each access carries its set number and its way in fixed address bit fields. Operating software uses the port to load entries, to inspect them, and to knock out a single stale translation.

The set number can be used as written, or hashed with the low bits of the current address-space ID when the hash-mode input is high. This matches the indexing the translation path would use. Tag reads hand back the raw stored entry with no comparison. The page number bits that were used as the set number come back as zero. A small access state machine drives the bus side: ST_IDLE (no read last cycle), ST_TAG_RD (tag word being returned), ST_DATA_RD (data word being returned) and ST_BAD (the last access missed both windows). It moves to the state set by each cycle's request (read in the tag window to ST_TAG_RD, read in the data window to ST_DATA_RD, any access outside both windows to ST_BAD, anything else to ST_IDLE). It never waits.

Top module: `tlb_window_port`

## Requirements
- R1: An access with address bits 31:24 equal to 0xF2 targets the tag store, and one with 0xF3 targets the data store.
- R2: With hash mode low, the set is address bits 16:12 and the way is address bits 9:8.
- R3: With hash mode high, the set is address bits 16:12 XOR cur_asid bits 4:0. The way is still address bits 9:8.
- R4: A tag write stores write-data bits 31:17 and 11:10 (page number), bit 8 (valid) and bits 7:0 (ID). A tag read returns them in the same positions, with bits 16:12 and bit 9 reading as zero.
- R5: A tag read returns the stored entry whatever the value of cur_asid and without any address comparison.
- R6: A tag write with bit 8 clear invalidates only the selected set and way. Every other entry keeps its value.
- R7: A data-window write stores all 32 bits of the write data in the selected set and way, and a data-window read returns that word unchanged.
- R8: After reset every entry's valid bit reads as 0.
- R9: An access whose bits 31:24 are neither 0xF2 nor 0xF3 changes no entry, returns zero read data, and raises win_miss for exactly the one following cycle.
- R10: Read data appears on bus_rdata in the cycle after the one in which bus_re is high. It is zero in any cycle not following a read. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Access address (window, set and way fields) |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| cur_asid | input | 8 | Current address-space ID |
| hash_en | input | 1 | Set-index hash mode |
| bus_rdata | output | 32 | Registered read data |
| win_miss | output | 1 | One-cycle flag for an out-of-window access |

## Verification
Every result of this block is due exactly one clock edge after the request. Writes are in the arrays at the edge that takes them, and read data and the miss flag are registered at that same edge. The bench drives a request on a falling edge and lets one rising edge pass. It samples bus_rdata and win_miss on the next falling edge, then drops the strobes or drives the next request. Its reference model computes the expected word before applying that cycle's write, so a read paired with a write is held to the old value.

// File: rtl/tlb_acc_pkg.sv
package tlb_acc_pkg;

    localparam logic [7:0] WIN_TAG  = 8'hF2;
    localparam logic [7:0] WIN_DATA = 8'hF3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TAG_RD,
        ST_DATA_RD,
        ST_BAD
    } acc_state_e;

    typedef struct packed {
        logic [14:0] vpn_hi;
        logic [1:0]  vpn_lo;
        logic [7:0]  asid;
    } tag_body_t;

endpackage

// File: rtl/tlb_acc_decode.sv
module tlb_acc_decode #(
    parameter int SET_W   = 5,
    parameter int WAY_W   = 2,
    parameter int IDX_LSB = 12,
    parameter int WAY_LSB = 8
) (
    input  logic [31:0]      addr,
    input  logic [7:0]       asid,
    input  logic             hash_en,
    output logic             in_tag,
    output logic             in_data,
    output logic [SET_W-1:0] set_idx,
    output logic [WAY_W-1:0] way_idx
);
    import tlb_acc_pkg::*;

    logic [SET_W-1:0] raw_set;
    logic             unused_decode_bits;

    assign raw_set = addr[IDX_LSB +: SET_W];
    assign in_tag  = (addr[31:24] == WIN_TAG);
    assign in_data = (addr[31:24] == WIN_DATA);
    assign way_idx = addr[WAY_LSB +: WAY_W];

    always_comb begin
        if (hash_en) begin
            set_idx = raw_set ^ asid[SET_W-1:0];
        end else begin
            set_idx = raw_set;
        end
    end

    assign unused_decode_bits = ^{addr, asid};

    always_comb begin
        a_win_exclusive_r1: assert (!(in_tag && in_data));
    end
endmodule

// File: rtl/tlb_tag_store.sv
module tlb_tag_store #(
    parameter int SET_W = 5,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SET_W-1:0] set_idx,
    input  logic [WAY_W-1:0] way_idx,
    input  logic [31:0]      wr_word,
    output logic [31:0]      rd_word
);
    import tlb_acc_pkg::*;

    localparam int PTR_W   = SET_W + WAY_W;
    localparam int ENTRIES = 1 << PTR_W;

    logic [PTR_W-1:0]   ptr;
    logic [ENTRIES-1:0] valid_q;
    tag_body_t          body_q [ENTRIES];
    tag_body_t          wr_body;
    tag_body_t          rd_body;
    logic               unused_tag_bits;

    assign ptr             = {set_idx, way_idx};
    assign wr_body.vpn_hi  = wr_word[31:17];
    assign wr_body.vpn_lo  = wr_word[11:10];
    assign wr_body.asid    = wr_word[7:0];
    assign unused_tag_bits = ^{wr_word[16:12], wr_word[9]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[ptr] <= wr_word[8];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            body_q[ptr] <= wr_body;
        end
    end

    assign rd_body = body_q[ptr];
    assign rd_word = {rd_body.vpn_hi, 5'b00000, rd_body.vpn_lo, 1'b0,
                      valid_q[ptr], rd_body.asid};

    p_reset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));

    p_single_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_q ^ $past(valid_q)) <= 1);

    p_valid_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(ptr)] == $past(wr_word[8])));

    p_no_write_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/tlb_data_store.sv
module tlb_data_store #(
    parameter int SET_W  = 5,
    parameter int WAY_W  = 2,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  set_idx,
    input  logic [WAY_W-1:0]  way_idx,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word
);
    localparam int PTR_W   = SET_W + WAY_W;
    localparam int ENTRIES = 1 << PTR_W;

    logic [PTR_W-1:0]  ptr;
    logic [WORD_W-1:0] mem_q [ENTRIES];

    assign ptr = {set_idx, way_idx};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[ptr] <= wr_word;
        end
    end

    assign rd_word = mem_q[ptr];

    p_data_lands_r7: assert property (@(posedge clk)
        wr_en |=> (mem_q[$past(ptr)] == $past(wr_word)));
endmodule

// File: rtl/tlb_acc_ctrl.sv
module tlb_acc_ctrl #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_re,
    input  logic              bus_we,
    input  logic              in_tag,
    input  logic              in_data,
    input  logic [WORD_W-1:0] tag_word,
    input  logic [WORD_W-1:0] data_word,
    output logic              tag_we,
    output logic              data_we,
    output logic [WORD_W-1:0] rdata,
    output logic              win_miss
);
    import tlb_acc_pkg::*;

    acc_state_e        state_q, state_d;
    logic [WORD_W-1:0] rdata_q;
    logic              outside;

    assign outside = !in_tag && !in_data;
    assign tag_we  = bus_we && in_tag;
    assign data_we = bus_we && in_data;

    always_comb begin
        if ((bus_re || bus_we) && outside) begin
            state_d = ST_BAD;
        end else if (bus_re && in_tag) begin
            state_d = ST_TAG_RD;
        end else if (bus_re && in_data) begin
            state_d = ST_DATA_RD;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            unique case (state_d)
                ST_TAG_RD:  rdata_q <= tag_word;
                ST_DATA_RD: rdata_q <= data_word;
                ST_BAD:     rdata_q <= '0;
                ST_IDLE:    rdata_q <= '0;
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign rdata    = rdata_q;
    assign win_miss = (state_q == ST_BAD);

    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_miss |-> (rdata == '0));

    p_miss_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_re || bus_we) && outside) |=> win_miss);

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (rdata == '0));
endmodule

// File: rtl/tlb_window_port.sv
module tlb_window_port #(
    parameter int SET_W   = 5,
    parameter int WAY_W   = 2,
    parameter int IDX_LSB = 12,
    parameter int WAY_LSB = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [7:0]  cur_asid,
    input  logic        hash_en,
    output logic [31:0] bus_rdata,
    output logic        win_miss
);
    logic             in_tag, in_data;
    logic [SET_W-1:0] set_idx;
    logic [WAY_W-1:0] way_idx;
    logic             tag_we, data_we;
    logic [31:0]      tag_word, data_word;

    tlb_acc_decode #(.SET_W(SET_W), .WAY_W(WAY_W), .IDX_LSB(IDX_LSB), .WAY_LSB(WAY_LSB)) u_dec (
        .addr(bus_addr), .asid(cur_asid), .hash_en(hash_en),
        .in_tag(in_tag), .in_data(in_data), .set_idx(set_idx), .way_idx(way_idx)
    );

    tlb_tag_store #(.SET_W(SET_W), .WAY_W(WAY_W)) u_tag (
        .clk(clk), .rst_n(rst_n), .wr_en(tag_we), .set_idx(set_idx),
        .way_idx(way_idx), .wr_word(bus_wdata), .rd_word(tag_word)
    );

    tlb_data_store #(.SET_W(SET_W), .WAY_W(WAY_W), .WORD_W(32)) u_data (
        .clk(clk), .wr_en(data_we), .set_idx(set_idx),
        .way_idx(way_idx), .wr_word(bus_wdata), .rd_word(data_word)
    );

    tlb_acc_ctrl #(.WORD_W(32)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_we(bus_we),
        .in_tag(in_tag), .in_data(in_data), .tag_word(tag_word),
        .data_word(data_word), .tag_we(tag_we), .data_we(data_we),
        .rdata(bus_rdata), .win_miss(win_miss)
    );

    p_miss_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_miss && !$past((bus_re || bus_we) && !in_tag && !in_data)) |-> 1'b0);
endmodule

// File: tb/test_tlb_window_port.sv
module test_tlb_window_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic        hash_en = 1'b0;
    logic [31:0] bus_rdata;
    logic        win_miss;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_tag  [128];
    logic [31:0] m_data [128];

    localparam logic [31:0] TAG_MASK = 32'hFFFE_0DFF;

    tlb_window_port i_tlb_window_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .cur_asid(cur_asid), .hash_en(hash_en),
        .bus_rdata(bus_rdata), .win_miss(win_miss)
    );

    always #4 clk = ~clk;

    function automatic int exp_ptr(logic [31:0] a, logic h, logic [7:0] as);
        logic [4:0] s;
        s = h ? (a[16:12] ^ as[4:0]) : a[16:12];
        return {s, a[9:8]};
    endfunction

    function automatic logic [31:0] mk_addr(logic [7:0] win, logic [4:0] s, logic [1:0] w);
        return {win, 7'd0, s, 2'd0, w, 8'd0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic op(logic [31:0] a, logic [31:0] wd, logic w, logic r,
                      logic h, logic [7:0] as, string req);
        int p;
        logic [31:0] exp;
        logic outside;
        bus_addr = a; bus_wdata = wd; bus_we = w; bus_re = r;
        hash_en = h; cur_asid = as;
        p = exp_ptr(a, h, as);
        outside = (a[31:24] != 8'hF2) && (a[31:24] != 8'hF3);
        exp = '0;
        if (r && a[31:24] == 8'hF2) exp = m_tag[p];
        if (r && a[31:24] == 8'hF3) exp = m_data[p];
        @(posedge clk);
        if (w && a[31:24] == 8'hF2) m_tag[p] = wd & TAG_MASK;
        if (w && a[31:24] == 8'hF3) m_data[p] = wd;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
        check(req, bus_rdata, exp);
        check({req, " R9 miss flag"}, {31'd0, win_miss}, {31'd0, outside && (w || r)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] v;
        int sd;
        sd = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset rdata", bus_rdata, 32'd0);
        check("R9 reset miss", {31'd0, win_miss}, 32'd0);

        // R8: valid bits clear after reset (only bit 8 is defined)
        for (int s = 0; s < 32; s += 7) begin
            for (int w = 0; w < 4; w++) begin
                bus_addr = mk_addr(8'hF2, s[4:0], w[1:0]); bus_re = 1'b1; hash_en = 1'b0;
                @(posedge clk); @(negedge clk); bus_re = 1'b0;
                check("R8 valid after reset", {31'd0, bus_rdata[8]}, 32'd0);
            end
        end

        // fill every entry with hash off (R2, R7)
        for (int s = 0; s < 32; s++) begin
            for (int w = 0; w < 4; w++) begin
                op(mk_addr(8'hF2, s[4:0], w[1:0]), $urandom | 32'h100, 1'b1, 1'b0, 1'b0, 8'h00, "R4 fill");
                op(mk_addr(8'hF3, s[4:0], w[1:0]), $urandom, 1'b1, 1'b0, 1'b0, 8'h00, "R7 fill");
            end
        end

        // R4: layout with all ones, unused bits zero
        op(mk_addr(8'hF2, 5'd3, 2'd1), 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 8'h00, "R4 write");
        op(mk_addr(8'hF2, 5'd3, 2'd1), 32'h0, 1'b0, 1'b1, 1'b0, 8'h00, "R4 read");
        check("R4 layout", m_tag[exp_ptr(mk_addr(8'hF2, 5'd3, 2'd1), 1'b0, 8'h0)], 32'hFFFE_0DFF);

        // R2/R7: data word at set 5 way 2
        op(mk_addr(8'hF3, 5'd5, 2'd2), 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 8'h00, "R7 write");
        op(mk_addr(8'hF3, 5'd5, 2'd2), 32'h0, 1'b0, 1'b1, 1'b0, 8'h00, "R2 R7 read");
        check("R7 word", bus_rdata, 32'hDEAD_BEEF);

        // R3: hashed read of set 15 with asid 0x0A reaches set 5
        op(mk_addr(8'hF3, 5'd15, 2'd2), 32'h0, 1'b0, 1'b1, 1'b1, 8'h0A, "R3 hashed read");
        check("R3 hashed set", bus_rdata, 32'hDEAD_BEEF);

        // R5: tag read with unrelated asid and hash off
        op(mk_addr(8'hF2, 5'd3, 2'd1), 32'h0, 1'b0, 1'b1, 1'b0, 8'h5C, "R5 no compare");
        check("R5 raw entry", bus_rdata, 32'hFFFE_0DFF);

        // R6: invalidate set 9 way 0; neighbours stay valid
        for (int w = 0; w < 4; w++)
            op(mk_addr(8'hF2, 5'd9, w[1:0]), 32'h0000_0155, 1'b1, 1'b0, 1'b0, 8'h00, "R6 setup");
        op(mk_addr(8'hF2, 5'd9, 2'd0), 32'h0000_0055, 1'b1, 1'b0, 1'b0, 8'h00, "R6 invalidate");
        for (int w = 0; w < 4; w++) begin
            op(mk_addr(8'hF2, 5'd9, w[1:0]), 32'h0, 1'b0, 1'b1, 1'b0, 8'h00, "R6 readback");
            check("R6 valid bit", {31'd0, bus_rdata[8]}, {31'd0, w != 0});
        end

        // R9: out-of-window write and read
        op({8'h12, 24'h00_5200}, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 8'h00, "R9 stray write");
        check("R9 flag one cycle", {31'd0, win_miss}, 32'd1);
        @(negedge clk);
        check("R9 flag drops", {31'd0, win_miss}, 32'd0);
        check("R10 idle rdata", bus_rdata, 32'd0);
        op({8'hF4, 24'h00_5200}, 32'h0, 1'b0, 1'b1, 1'b0, 8'h00, "R9 stray read");
        op(mk_addr(8'hF2, 5'd5, 2'd2), 32'h0, 1'b0, 1'b1, 1'b0, 8'h00, "R9 tag untouched");

        // R10: read and write together return the old value
        v = m_data[exp_ptr(mk_addr(8'hF3, 5'd7, 2'd3), 1'b0, 8'h0)];
        op(mk_addr(8'hF3, 5'd7, 2'd3), 32'h1234_5678, 1'b1, 1'b1, 1'b0, 8'h00, "R10 read-with-write");
        check("R10 old value", bus_rdata, v);

        // random mix (R1, R2, R3)
        for (int i = 0; i < 3000; i++) begin
            int k;
            k = $urandom_range(0, 9);
            a = $urandom;
            if (k < 4) a[31:24] = 8'hF2;
            else if (k < 9) a[31:24] = 8'hF3;
            else if (a[31:25] == 7'h79) a[31:24] = 8'h00;
            op(a, $urandom, ($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 1),
               $urandom_range(0, 1) == 1, 8'($urandom), "R1 R3 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule